// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the wall-clock time and the calendar date as seven packed BCD byte registers: seconds, minutes, hours, weekday, day of month, month and year. A free-running prescaler counts tick-enable pulses from a slower clock domain that has already been brought onto `clk`. After `TICKS_PER_SEC` of them the time advances by one second, carrying through minutes, hours, weekday, date, month and year. The hours byte can hold either a 24-hour value or a 12-hour value with a PM flag. The month byte carries a century flag that flips each time the year wraps.

Software or a bus bridge loads any register with a single-cycle byte write. Loading the seconds register also restarts the sub-second prescaler, so the next second begins at the moment of that write. An optional 1 Hz square wave is derived from the prescaler phase: it is low for the first half of each second and high for the second half. All seven registers are visible on the ports at all times. A one-cycle pulse marks every per-second update.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour mode), weekday 01, date 01, month 01 with the century flag clear, and year 00. Every register holds packed BCD: tens digit in bits 7:4, units digit in bits 3:0.
- R2: Seconds advance by one after every `TICKS_PER_SEC` asserted `tick_en` cycles. `tick_sec` is high for exactly one cycle, and the new values are visible in that same cycle. Seconds wrap 59 to 00 and then increment minutes. Minutes wrap 59 to 00 and then increment hours.
- R3: When hours bit 6 is 0 (24-hour mode), bits 5:0 count 00 to 23 in BCD. 23 wraps to 00 and starts a new day.
- R4: When hours bit 6 is 1 (12-hour mode), bit 5 is the PM flag (1 = PM) and bits 4:0 run 12, 01 … 11. Going from 11 to 12 inverts the PM flag. Only the step from 11 PM to 12 AM starts a new day.
- R5: The weekday register (values 1 to 7) increments on each new day and wraps from 7 to 1.
- R6: On a new day the date increments. It returns to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and after 29 in month 02 when the two-digit year is a multiple of 4 (28 otherwise).
- R7: When the date returns to 01, the month (bits 4:0) increments. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and inverts month bit 7, the century flag.
- R8: A write with `wr_en` high stores `wr_data` in the addressed register, and the value is visible in the next cycle. Addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. A write to address 7 changes nothing.
- R9: A write to the seconds register restarts the prescaler. The next per-second update comes after exactly `TICKS_PER_SEC` asserted `tick_en` cycles counted from the write.
- R10: With `sqw_en` high, `sqw` is low for the first `TICKS_PER_SEC/2` tick-enables after a restart or update and high for the rest of the second. With `sqw_en` low, `sqw` stays low.
- R11: A seconds write in the cycle in which the prescaler would complete a second cancels that update: no `tick_sec` pulse and no carry. A write to any other register in that cycle lets the update proceed, and the written register takes `wr_data` instead of its advanced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler tick enable, `TICKS_PER_SEC` per second |
| sqw_en | input | 1 | Enables the 1 Hz square wave |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | BCD byte to store |
| t_sec | output | 8 | Seconds register |
| t_min | output | 8 | Minutes register |
| t_hour | output | 8 | Hours register with mode and PM bits |
| t_wday | output | 8 | Weekday register |
| t_mday | output | 8 | Day-of-month register |
| t_mon | output | 8 | Month register with century flag in bit 7 |
| t_year | output | 8 | Two-digit year register |
| tick_sec | output | 1 | One-cycle pulse on each per-second update |
| sqw | output | 1 | 1 Hz square wave |

## Verification
Two functions can fall in the same cycle: a register write from the port and the per-second update that ends a prescaler period. The bench provokes this by first writing seconds to restart the prescaler. It then holds `tick_en` high and places a second write exactly in the cycle where the last tick of the second arrives, once for the seconds register and once for minutes with seconds at 59. It judges the result by whether `tick_sec` fires, by the value the written register holds, and by whether the carry into the other registers happened. For a cancelled update it also times the following update from the new restart.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NUM_REGS = 7;
   localparam int ADDR_W   = 3;
   localparam int BYTE_W   = 8;

   localparam int I_SEC  = 0;
   localparam int I_MIN  = 1;
   localparam int I_HOUR = 2;
   localparam int I_WDAY = 3;
   localparam int I_MDAY = 4;
   localparam int I_MON  = 5;
   localparam int I_YEAR = 6;

   // increment one packed BCD byte (caller keeps it in range)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last day of a BCD month; 10*T+U is divisible by 4 iff 2*T+U is
   function automatic logic [7:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
      logic [4:0] s;
      s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      case (mon)
         5'h02:                      return (s[1:0] == 2'd0) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] reset_value(input int idx);
      case (idx)
         I_WDAY, I_MDAY, I_MON: return 8'h01;
         default:               return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS_PER_SEC = 32768,
   parameter bit HAS_SQW       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en_i,
   input  logic restart_i,
   input  logic sqw_en_i,
   output logic strobe_o,
   output logic sqw_o
);
   localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST   = CW'(TICKS_PER_SEC - 1);
   localparam logic [CW-1:0] HALF_C = CW'(TICKS_PER_SEC / 2);

   if (TICKS_PER_SEC < 2 || (TICKS_PER_SEC % 2) != 0) begin : g_bad_ticks
      $error("rtc_prescaler: TICKS_PER_SEC must be even and at least 2");
   end

   logic [CW-1:0] cnt;

   // a restart in the wrap cycle cancels the update
   assign strobe_o = tick_en_i && (cnt == LAST) && !restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (restart_i) cnt <= '0;
      else if (tick_en_i) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
   end

   if (HAS_SQW) begin : g_sqw
      assign sqw_o = sqw_en_i && (cnt >= HALF_C);
   end else begin : g_no_sqw
      assign sqw_o = 1'b0;
   end
endmodule

// File: rtl/rtc_hour_next.sv
module rtc_hour_next
   import rtc_pkg::*;
(
   input  logic [7:0] hour_i,
   output logic [7:0] hour_o,
   output logic       day_o
);
   always_comb begin
      hour_o = hour_i;
      day_o  = 1'b0;
      if (hour_i[6]) begin
         case (hour_i[4:0])
            5'h11: begin
               hour_o = {hour_i[7:6], ~hour_i[5], 5'h12};
               day_o  = hour_i[5];
            end
            5'h12:   hour_o = {hour_i[7:5], 5'h01};
            default: hour_o = {hour_i[7:5], 5'h00} | (bcd_inc({3'b000, hour_i[4:0]}) & 8'h1F);
         endcase
      end else begin
         if (hour_i[5:0] == 6'h23) begin
            hour_o = {hour_i[7:6], 6'h00};
            day_o  = 1'b1;
         end else begin
            hour_o = {hour_i[7:6], 6'h00} | (bcd_inc({2'b00, hour_i[5:0]}) & 8'h3F);
         end
      end
   end
endmodule

// File: rtl/rtc_date_next.sv
module rtc_date_next
   import rtc_pkg::*;
(
   input  logic [7:0] mday_i,
   input  logic [7:0] mon_i,
   input  logic [7:0] year_i,
   output logic [7:0] mday_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o
);
   logic [7:0] last_day;
   assign last_day = month_len(mon_i[4:0], year_i);

   always_comb begin
      mday_o = bcd_inc(mday_i);
      mon_o  = mon_i;
      year_o = year_i;
      if (mday_i == last_day) begin
         mday_o = 8'h01;
         if (mon_i[4:0] == 5'h12) begin
            mon_o  = {mon_i[7] ^ (year_i == 8'h99), mon_i[6:5], 5'h01};
            year_o = (year_i == 8'h99) ? 8'h00 : bcd_inc(year_i);
         end else begin
            mon_o = {mon_i[7:5], 5'h00} | (bcd_inc({3'b000, mon_i[4:0]}) & 8'h1F);
         end
      end
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter bit HAS_SQW       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              sqw_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] t_sec,
   output logic [BYTE_W-1:0] t_min,
   output logic [BYTE_W-1:0] t_hour,
   output logic [BYTE_W-1:0] t_wday,
   output logic [BYTE_W-1:0] t_mday,
   output logic [BYTE_W-1:0] t_mon,
   output logic [BYTE_W-1:0] t_year,
   output logic              tick_sec,
   output logic              sqw
);
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("rtc_calendar: address width too small for register count");
   end

   logic [BYTE_W-1:0] regs  [NUM_REGS];
   logic [BYTE_W-1:0] adv_v [NUM_REGS];
   logic [BYTE_W-1:0] hour_nx, mday_nx, mon_nx, year_nx;
   logic strobe, sec_wr, day_wrap, sec_wrap, min_wrap, hour_step, day_step;

   assign sec_wr = wr_en && (wr_addr == ADDR_W'(I_SEC));

   rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .HAS_SQW(HAS_SQW)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .restart_i(sec_wr),
      .sqw_en_i(sqw_en), .strobe_o(strobe), .sqw_o(sqw));

   rtc_hour_next u_hour (.hour_i(regs[I_HOUR]), .hour_o(hour_nx), .day_o(day_wrap));

   rtc_date_next u_date (
      .mday_i(regs[I_MDAY]), .mon_i(regs[I_MON]), .year_i(regs[I_YEAR]),
      .mday_o(mday_nx), .mon_o(mon_nx), .year_o(year_nx));

   // one-second advance of the whole register set
   always_comb begin
      sec_wrap  = (regs[I_SEC] == 8'h59);
      min_wrap  = (regs[I_MIN] == 8'h59);
      hour_step = sec_wrap && min_wrap;
      day_step  = hour_step && day_wrap;
      adv_v[I_SEC]  = sec_wrap ? 8'h00 : bcd_inc(regs[I_SEC]);
      adv_v[I_MIN]  = !sec_wrap ? regs[I_MIN] : (min_wrap ? 8'h00 : bcd_inc(regs[I_MIN]));
      adv_v[I_HOUR] = hour_step ? hour_nx : regs[I_HOUR];
      adv_v[I_WDAY] = !day_step ? regs[I_WDAY] :
                      ((regs[I_WDAY] == 8'h07) ? 8'h01 : bcd_inc(regs[I_WDAY]));
      adv_v[I_MDAY] = day_step ? mday_nx : regs[I_MDAY];
      adv_v[I_MON]  = day_step ? mon_nx  : regs[I_MON];
      adv_v[I_YEAR] = day_step ? year_nx : regs[I_YEAR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(i);
         tick_sec <= 1'b0;
      end else begin
         tick_sec <= strobe;
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_addr == ADDR_W'(i)) regs[i] <= wr_data;
            else if (strobe)                    regs[i] <= adv_v[i];
         end
      end
   end

   assign t_sec  = regs[I_SEC];
   assign t_min  = regs[I_MIN];
   assign t_hour = regs[I_HOUR];
   assign t_wday = regs[I_WDAY];
   assign t_mday = regs[I_MDAY];
   assign t_mon  = regs[I_MON];
   assign t_year = regs[I_YEAR];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic       sqw,
   input logic       tick_sec,
   input logic [7:0] t_sec,
   input logic [7:0] t_hour,
   input logic [7:0] t_wday,
   input logic [7:0] t_mon,
   input logic [7:0] t_year
);
   p_sec_bcd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (t_sec[3:0] <= 4'd9) && (t_sec[7:4] <= 4'd5));

   p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_sec |=> !tick_sec);

   p_sec_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(t_sec) |-> (tick_sec || $past(wr_en)));

   p_hour12_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      t_hour[6] |-> (t_hour[4:0] != 5'h00) && (!t_hour[4] || t_hour[3:0] <= 4'd2));

   p_wday_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (t_wday >= 8'h01) && (t_wday <= 8'h07));

   p_century_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $past(t_year) == 8'h99 && t_year == 8'h00)
         |-> (t_mon[7] != $past(t_mon[7])));

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_addr == 3'd0) |-> (!sqw && !tick_sec));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .sqw(sqw),
   .tick_sec(tick_sec), .t_sec(t_sec), .t_hour(t_hour), .t_wday(t_wday),
   .t_mon(t_mon), .t_year(t_year));

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
   localparam int TPS = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, sqw_en = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year;
   logic tick_sec, sqw;

   int checks = 0, failures = 0, pcnt = 0;
   bit finished = 1'b0;

   // bench-side calendar model in plain binary
   int m_s, m_m, m_h, m_wd, m_md, m_mo, m_y, m_cen;
   bit m_12;

   always #4 clk = ~clk;

   rtc_calendar #(.TICKS_PER_SEC(TPS), .HAS_SQW(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sqw_en(sqw_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .t_sec(t_sec), .t_min(t_min),
      .t_hour(t_hour), .t_wday(t_wday), .t_mday(t_mday), .t_mon(t_mon),
      .t_year(t_year), .tick_sec(tick_sec), .sqw(sqw));

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int days_in(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] hour_byte(input bit twelve, input int h);
      int h12;
      if (!twelve) return bcd(h);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return 8'h40 | (h >= 12 ? 8'h20 : 8'h00) | bcd(h12);
   endfunction

   function automatic logic [55:0] model_vec();
      return {bcd(m_y), 8'(m_cen << 7) | bcd(m_mo), bcd(m_md), bcd(m_wd),
              hour_byte(m_12, m_h), bcd(m_m), bcd(m_s)};
   endfunction

   function automatic logic [55:0] dut_vec();
      return {t_year, t_mon, t_mday, t_wday, t_hour, t_min, t_sec};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_step();
      m_s++;
      if (m_s == 60) begin
         m_s = 0; m_m++;
         if (m_m == 60) begin
            m_m = 0; m_h++;
            if (m_h == 24) begin
               m_h = 0;
               m_wd = (m_wd == 7) ? 1 : m_wd + 1;
               m_md++;
               if (m_md > days_in(m_mo, m_y)) begin
                  m_md = 1; m_mo++;
                  if (m_mo == 13) begin
                     m_mo = 1; m_y++;
                     if (m_y == 100) begin m_y = 0; m_cen ^= 1; end
                  end
               end
            end
         end
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_all(input bit twelve, input int h, input int m, input int s,
                          input int wd, input int md, input int mo, input int y, input int cen);
      tick_en = 1'b0;
      m_12 = twelve; m_h = h; m_m = m; m_s = s; m_wd = wd;
      m_md = md; m_mo = mo; m_y = y; m_cen = cen;
      wr(2, hour_byte(twelve, h));
      wr(1, bcd(m));
      wr(3, bcd(wd));
      wr(4, bcd(md));
      wr(5, 8'(cen << 7) | bcd(mo));
      wr(6, bcd(y));
      wr(0, bcd(s));
   endtask

   // run one second: drive tick enables until the pulse, then compare with the model
   task automatic step_check(input string req, input bit dense);
      int ticks = 0, guard = 0;
      bit seen = 1'b0;
      while (!seen && guard < 64) begin
         @(negedge clk);
         guard++;
         if (tick_sec) begin
            seen = 1'b1;
            tick_en = 1'b0;
         end else begin
            pcnt++;
            tick_en = dense ? 1'b1 : ((pcnt % 3) != 1);
            if (tick_en) ticks++;
         end
      end
      model_step();
      chk(req, 64'(dut_vec()), 64'(model_vec()));
      chk("R2 ticks per second", 64'(ticks), 64'(TPS));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL R2 watchdog actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [55:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset regs", 64'(dut_vec()),
          64'({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00}));
      chk("R1 reset pulse/sqw", 64'({tick_sec, sqw}), 64'(0));

      // R8 write visible next cycle, address 7 ignored
      wr(1, 8'h42);
      chk("R8 minutes write", 64'(t_min), 64'(8'h42));
      snap = dut_vec();
      wr(7, 8'h99);
      chk("R8 address 7 ignored", 64'(dut_vec()), 64'(snap));
      chk("R8 address 7 no pulse", 64'(tick_sec), 64'(0));

      // R3 / R4 exhaustive hour transitions in both encodings
      for (int mode = 0; mode < 2; mode++) begin
         for (int h = 0; h < 24; h++) begin
            set_all(mode[0], h, 59, 59, (h % 7) + 1, 15, 6, 5, 0);
            step_check(mode == 0 ? "R3 hour step" : "R4 hour step", 1'b1);
         end
      end

      // R5 weekday wraps 7 to 1 at midnight
      set_all(1'b0, 23, 59, 59, 7, 10, 3, 10, 0);
      step_check("R5 weekday wrap", 1'b1);
      chk("R5 weekday is 1", 64'(t_wday), 64'(8'h01));

      // R6 / R7 month ends over eight years, leap and non-leap
      for (int y = 0; y < 8; y++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_all(y[0], 23, 59, 59, (mo % 7) + 1, days_in(mo, y), mo, y, y % 2);
            step_check(mo == 12 ? "R7 year step" : "R6 month end", 1'b1);
         end
      end
      set_all(1'b0, 23, 59, 59, 2, 27, 2, 1, 0);
      step_check("R6 feb 27 to 28", 1'b1);

      // R7 year 99 wraps and flips the century flag, both directions
      for (int c = 0; c < 2; c++) begin
         set_all(1'b1, 23, 59, 59, 3, 31, 12, 99, c);
         step_check("R7 century flip", 1'b1);
         chk("R7 century bit", 64'(t_mon[7]), 64'(c == 0 ? 1 : 0));
      end

      // R2 / R4 long run with sparse tick enables across noon
      set_all(1'b1, 11, 58, 30, 2, 28, 2, 24, 1);
      for (int n = 0; n < 100; n++) step_check("R2 run 12h", 1'b0);
      // R2 / R3 run across midnight into a leap day
      set_all(1'b0, 23, 58, 40, 6, 28, 2, 24, 0);
      for (int n = 0; n < 100; n++) step_check("R2 run 24h", 1'b1);

      // R9 / R10 square wave phase after a seconds write
      set_all(1'b0, 10, 20, 5, 4, 5, 5, 5, 0);
      sqw_en = 1'b1;
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h10; tick_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      chk("R10 sqw low after restart", 64'(sqw), 64'(0));
      @(negedge clk); chk("R10 sqw low 1st half", 64'(sqw), 64'(0));
      @(negedge clk); chk("R10 sqw high 2nd half", 64'(sqw), 64'(1));
      @(negedge clk); chk("R10 sqw high late", 64'({sqw, tick_sec}), 64'(2'b10));
      @(negedge clk);
      chk("R9 update after TPS ticks", 64'({tick_sec, sqw, t_sec}), 64'({2'b10, 8'h11}));
      sqw_en = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); chk("R10 sqw disabled", 64'(sqw), 64'(0));
      end
      tick_en = 1'b0;

      // R11 seconds write lands in the wrap cycle: update cancelled
      set_all(1'b0, 10, 20, 5, 4, 5, 5, 5, 0);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h59; tick_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h45;
      @(negedge clk); wr_en = 1'b0;
      chk("R11 sec write wins, no pulse", 64'({tick_sec, t_min, t_sec}), 64'({1'b0, 8'h20, 8'h45}));
      repeat (3) @(negedge clk);
      chk("R11 no pulse before TPS", 64'(tick_sec), 64'(0));
      @(negedge clk);
      chk("R9 next update after restart", 64'({tick_sec, t_sec}), 64'({1'b1, 8'h46}));
      tick_en = 1'b0;

      // R11 minutes write lands in the wrap cycle: update proceeds, write wins
      set_all(1'b0, 10, 5, 0, 4, 5, 5, 5, 0);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h59; tick_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h10;
      @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
      chk("R11 other write with update", 64'({tick_sec, t_hour, t_min, t_sec}),
          64'({1'b1, 8'h10, 8'h10, 8'h00}));

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule